// File: doc/BRIEF.md
# FMA NaN Propagation Selector

This combinational unit sits beside the arithmetic of a fused multiply-add datapath that computes A×B+C. It inspects the three operands and decides whether the final result must be a NaN. When it must, the unit decides which operand's NaN carries through, or whether a freshly generated default NaN is needed. It then delivers that NaN in quiet form, together with the invalid-operation flag and a separate flag for the infinity-times-zero product.

A precision input selects single precision, with the operand in the low 32 bits, or double precision, with the full 64 bits. The same selector therefore serves both widths of multiply-add. A mode input switches to two-operand operation, in which only A and B are examined, so that ordinary binary operations can reuse the unit. The unit does not perform the multiply-add arithmetic, the rounding or the non-NaN result path.

Top module: `fma_nan_pick`

## Requirements
- R1: An operand whose exponent field is all ones and whose fraction is nonzero is a NaN. When no examined operand is a NaN and the infinity-times-zero rule does not fire, nan_valid, invalid and invalid_imz are 0, sel is 0 and result is 0.
- R2: In three-operand mode (mode3=1), if one of A and B is an infinity, the other is a zero, and C is a NaN, then sel=2, result is C quieted, nan_valid=1, invalid=1 and invalid_imz=1.
- R3: In three-operand mode, if one of A and B is an infinity, the other is a zero, and C is not a NaN, then sel=3, nan_valid=1, invalid=1, invalid_imz=1 and result is the default quiet NaN: positive sign, exponent all ones, only the fraction MSB set (0x7FC00000 in single, 0x7FF8000000000000 in double).
- R4: In three-operand mode, outside the R2/R3 cases, signalling NaNs are searched first in the order C, B, A, and the first one found is selected (sel 2, 1, 0 for C, B, A).
- R5: In three-operand mode, with no signalling NaN present but some NaN present, a quiet NaN in C gives sel=2, otherwise a quiet NaN in B gives sel=1, otherwise sel=0.
- R6: In two-operand mode (mode3=0), a signalling NaN in B gives sel=1, then a signalling NaN in A gives sel=0, then a quiet NaN in B gives sel=1, and otherwise sel=0. invalid_imz stays 0 in this mode.
- R7: In two-operand mode, operand C has no effect on any output.
- R8: The result for a propagated NaN is the selected operand with its fraction MSB forced to 1. Its sign and all of its other bits are unchanged.
- R9: Outside the R2/R3 cases, invalid is 1 exactly when an examined operand is a signalling NaN (a fraction MSB of 0), and invalid_imz is 0.
- R10: In single precision (is_dbl=0), operand bits 63..32 are ignored and result bits 63..32 are 0.
- R11: The same rules apply to double precision (is_dbl=1), where a NaN is quieted at bit 51 instead of bit 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode3 | input | 1 | 1: three-operand multiply-add, 0: two-operand |
| is_dbl | input | 1 | 1: double precision, 0: single precision in bits 31..0 |
| op_a | input | 64 | Operand A (multiplicand) |
| op_b | input | 64 | Operand B (multiplier) |
| op_c | input | 64 | Operand C (addend) |
| nan_valid | output | 1 | The result must be a NaN |
| sel | output | 2 | Chosen operand 0/1/2 for A/B/C, 3 for the default NaN |
| result | output | 64 | Quieted NaN result |
| invalid | output | 1 | Invalid-operation flag |
| invalid_imz | output | 1 | Infinity-times-zero sub-flag |

## Verification
The bench builds the unit with its default field widths: an 8-bit exponent with a 23-bit fraction, and an 11-bit exponent with a 52-bit fraction. This places single and double precision in one instance, switched by is_dbl. The bench runs all 125 class combinations of {finite, zero, infinity, quiet NaN, signalling NaN} over A, B and C, in both modes and both precisions. The values carry random signs, payloads and, in single precision, random upper halves, so the payload retention and the masking of the upper half are exercised throughout. Random raw bit patterns follow, and then directed vectors that change C in two-operand mode.

// File: rtl/fma_nan_pkg.sv
// Package fma_nan_pkg: shared operand class type and format constants
// for the FMA NaN selector.
package fma_nan_pkg;
    typedef enum logic [2:0] {
        CLS_FIN  = 3'd0,
        CLS_ZERO = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } opclass_t;

    localparam logic [1:0] SEL_A   = 2'd0;
    localparam logic [1:0] SEL_B   = 2'd1;
    localparam logic [1:0] SEL_C   = 2'd2;
    localparam logic [1:0] SEL_DEF = 2'd3;
endpackage

// File: rtl/fnan_classify.sv
// fnan_classify: sorts one operand into a class (finite, zero, infinity,
// quiet NaN, signalling NaN).
// Assumes: single precision sits in the low SW bits; subnormals count as finite.
module fnan_classify
    import fma_nan_pkg::*;
#(
    parameter int SGL_EXP  = 8,
    parameter int SGL_FRAC = 23,
    parameter int DBL_EXP  = 11,
    parameter int DBL_FRAC = 52,
    localparam int DW = 1 + DBL_EXP + DBL_FRAC
) (
    input  logic          is_dbl,
    input  logic [DW-1:0] op,
    output opclass_t      cls
);
    logic [SGL_EXP-1:0]  exp_s;
    logic [SGL_FRAC-1:0] frac_s;
    logic [DBL_EXP-1:0]  exp_d;
    logic [DBL_FRAC-1:0] frac_d;
    logic exp_ones, exp_zero, frac_zero, frac_msb;

    // Pick the fields of the active precision.
    always_comb begin
        exp_s  = op[SGL_FRAC +: SGL_EXP];
        frac_s = op[SGL_FRAC-1:0];
        exp_d  = op[DBL_FRAC +: DBL_EXP];
        frac_d = op[DBL_FRAC-1:0];
        exp_ones  = is_dbl ? (&exp_d)  : (&exp_s);
        exp_zero  = is_dbl ? ~(|exp_d) : ~(|exp_s);
        frac_zero = is_dbl ? ~(|frac_d) : ~(|frac_s);
        frac_msb  = is_dbl ? frac_d[DBL_FRAC-1] : frac_s[SGL_FRAC-1];
    end

    // Map the field tests to a class.
    always_comb begin
        if (exp_ones)
            cls = frac_zero ? CLS_INF : (frac_msb ? CLS_QNAN : CLS_SNAN);
        else if (exp_zero && frac_zero)
            cls = CLS_ZERO;
        else
            cls = CLS_FIN;
    end
endmodule

// File: rtl/fnan_priority.sv
// fnan_priority: applies the infinity-times-zero rule and the NaN priority
// (signalling before quiet, scanned C, B, A; or B, A in two-operand mode).
// Assumes: classes come from fnan_classify.
module fnan_priority
    import fma_nan_pkg::*;
(
    input  logic     mode3,
    input  opclass_t cls_a,
    input  opclass_t cls_b,
    input  opclass_t cls_c,
    output logic       nan_valid,
    output logic [1:0] sel,
    output logic       invalid,
    output logic       invalid_imz
);
    logic sn_a, sn_b, sn_c, qn_b, qn_c, nan_a, nan_b, nan_c, imz;

    // Per-operand NaN tests; C counts only in three-operand mode.
    always_comb begin
        sn_a  = (cls_a == CLS_SNAN);
        sn_b  = (cls_b == CLS_SNAN);
        sn_c  = mode3 && (cls_c == CLS_SNAN);
        qn_b  = (cls_b == CLS_QNAN);
        qn_c  = mode3 && (cls_c == CLS_QNAN);
        nan_a = sn_a || (cls_a == CLS_QNAN);
        nan_b = sn_b || qn_b;
        nan_c = sn_c || qn_c;
        imz   = mode3 && (((cls_a == CLS_INF) && (cls_b == CLS_ZERO)) ||
                          ((cls_a == CLS_ZERO) && (cls_b == CLS_INF)));
    end

    // Priority decision.
    always_comb begin
        nan_valid   = 1'b0;
        sel         = SEL_A;
        invalid     = sn_a || sn_b || sn_c;
        invalid_imz = 1'b0;
        if (imz) begin
            nan_valid   = 1'b1;
            invalid     = 1'b1;
            invalid_imz = 1'b1;
            sel         = nan_c ? SEL_C : SEL_DEF;
        end else if (nan_a || nan_b || nan_c) begin
            nan_valid = 1'b1;
            if (sn_c)      sel = SEL_C;
            else if (sn_b) sel = SEL_B;
            else if (sn_a) sel = SEL_A;
            else if (qn_c) sel = SEL_C;
            else if (qn_b) sel = SEL_B;
            else           sel = SEL_A;
        end
    end
endmodule

// File: rtl/fnan_quiet.sv
// fnan_quiet: forms the output NaN, either the chosen operand with its
// fraction MSB set or the default quiet NaN.
// Assumes: sel and nan_valid come from fnan_priority.
module fnan_quiet
    import fma_nan_pkg::*;
#(
    parameter int SGL_EXP  = 8,
    parameter int SGL_FRAC = 23,
    parameter int DBL_EXP  = 11,
    parameter int DBL_FRAC = 52,
    localparam int DW = 1 + DBL_EXP + DBL_FRAC,
    localparam int SW = 1 + SGL_EXP + SGL_FRAC
) (
    input  logic          is_dbl,
    input  logic          nan_valid,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [DW-1:0] op_c,
    output logic [DW-1:0] result
);
    localparam logic [DW-1:0] QBIT_D = DW'(1) << (DBL_FRAC - 1);
    localparam logic [DW-1:0] QBIT_S = DW'(1) << (SGL_FRAC - 1);
    localparam logic [DW-1:0] DEF_D  = ((DW'(1) << DBL_EXP) - 1) << DBL_FRAC | QBIT_D;
    localparam logic [DW-1:0] DEF_S  = ((DW'(1) << SGL_EXP) - 1) << SGL_FRAC | QBIT_S;
    localparam logic [DW-1:0] LOW_S  = (DW'(1) << SW) - 1;

    logic [DW-1:0] pick;

    // Choose the source operand.
    always_comb begin
        case (sel)
            SEL_A:   pick = op_a;
            SEL_B:   pick = op_b;
            default: pick = op_c;
        endcase
    end

    // Quiet it, or emit the default NaN, masked to the active width.
    always_comb begin
        if (!nan_valid)
            result = '0;
        else if (sel == SEL_DEF)
            result = is_dbl ? DEF_D : DEF_S;
        else if (is_dbl)
            result = pick | QBIT_D;
        else
            result = (pick & LOW_S) | QBIT_S;
    end
endmodule

// File: rtl/fma_nan_pick.sv
// fma_nan_pick: top of the FMA NaN propagation selector. Classifies the
// three operands, chooses the NaN to propagate and returns it quieted with
// the invalid flags.
// Assumes: purely combinational; the caller registers the outputs.
module fma_nan_pick
    import fma_nan_pkg::*;
#(
    parameter int SGL_EXP  = 8,
    parameter int SGL_FRAC = 23,
    parameter int DBL_EXP  = 11,
    parameter int DBL_FRAC = 52,
    localparam int DW = 1 + DBL_EXP + DBL_FRAC,
    localparam int SW = 1 + SGL_EXP + SGL_FRAC
) (
    input  logic          mode3,
    input  logic          is_dbl,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [DW-1:0] op_c,
    output logic          nan_valid,
    output logic [1:0]    sel,
    output logic [DW-1:0] result,
    output logic          invalid,
    output logic          invalid_imz
);
    logic [2:0][DW-1:0] ops;
    opclass_t           cls [3];

    assign ops = {op_c, op_b, op_a};

    for (genvar g = 0; g < 3; g++) begin : g_cls
        fnan_classify #(
            .SGL_EXP(SGL_EXP), .SGL_FRAC(SGL_FRAC),
            .DBL_EXP(DBL_EXP), .DBL_FRAC(DBL_FRAC)
        ) cls_i (
            .is_dbl(is_dbl),
            .op    (ops[g]),
            .cls   (cls[g])
        );
    end

    fnan_priority prio_i (
        .mode3      (mode3),
        .cls_a      (cls[0]),
        .cls_b      (cls[1]),
        .cls_c      (cls[2]),
        .nan_valid  (nan_valid),
        .sel        (sel),
        .invalid    (invalid),
        .invalid_imz(invalid_imz)
    );

    fnan_quiet #(
        .SGL_EXP(SGL_EXP), .SGL_FRAC(SGL_FRAC),
        .DBL_EXP(DBL_EXP), .DBL_FRAC(DBL_FRAC)
    ) quiet_i (
        .is_dbl   (is_dbl),
        .nan_valid(nan_valid),
        .sel      (sel),
        .op_a     (op_a),
        .op_b     (op_b),
        .op_c     (op_c),
        .result   (result)
    );

    // Output consistency checks across the three sub-blocks.
    always_comb begin
        // R1
        no_nan_idle_chk: assert (nan_valid || (result == '0 && !invalid && !invalid_imz));
        // R8
        quiet_bit_chk: assert (!nan_valid ||
            (is_dbl ? result[DBL_FRAC-1] : result[SGL_FRAC-1]));
        // R2
        imz_flag_chk: assert (!invalid_imz || (invalid && nan_valid && sel[1]));
        // R6
        two_op_imz_chk: assert (mode3 || (!invalid_imz && sel != SEL_C && sel != SEL_DEF));
        // R10
        single_upper_chk: assert (is_dbl || result[DW-1:SW] == '0);
    end
endmodule

// File: tb/fma_nan_pick_tb.sv
// fma_nan_pick_tb_top: exhaustive class sweep, random raw patterns and
// directed cases, checked against a behavioural priority model.
module fma_nan_pick_tb_top;
    logic clk = 1'b0;
    logic mode3, is_dbl;
    logic [63:0] op_a, op_b, op_c;
    logic nan_valid, invalid, invalid_imz;
    logic [1:0] sel;
    logic [63:0] result;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    fma_nan_pick dut_i (
        .mode3(mode3), .is_dbl(is_dbl), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .nan_valid(nan_valid), .sel(sel), .result(result),
        .invalid(invalid), .invalid_imz(invalid_imz)
    );

    // class codes: 0 finite, 1 zero, 2 inf, 3 qnan, 4 snan
    function automatic int tcls(bit dbl, logic [63:0] x);
        logic eo, ez, fz, msb;
        eo  = dbl ? (&x[62:52]) : (&x[30:23]);
        ez  = dbl ? (x[62:52] == 0) : (x[30:23] == 0);
        fz  = dbl ? (x[51:0] == 0) : (x[22:0] == 0);
        msb = dbl ? x[51] : x[22];
        if (eo) return fz ? 2 : (msb ? 3 : 4);
        if (ez && fz) return 1;
        return 0;
    endfunction

    function automatic logic [63:0] gen(int c, bit dbl);
        logic [63:0] v;
        v = {$urandom, $urandom};
        if (dbl) begin
            case (c)
                0: v[62:52] = 11'($urandom_range(1, 2046));
                1: v[62:0] = '0;
                2: v[62:0] = {11'h7FF, 52'h0};
                3: begin v[62:52] = 11'h7FF; v[51] = 1'b1; end
                default: begin v[62:52] = 11'h7FF; v[51] = 1'b0; if (v[50:0] == 0) v[0] = 1'b1; end
            endcase
        end else begin
            case (c)
                0: v[30:23] = 8'($urandom_range(1, 254));
                1: v[30:0] = '0;
                2: v[30:0] = {8'hFF, 23'h0};
                3: begin v[30:23] = 8'hFF; v[22] = 1'b1; end
                default: begin v[30:23] = 8'hFF; v[22] = 1'b0; if (v[21:0] == 0) v[0] = 1'b1; end
            endcase
        end
        return v;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Apply one vector, compute the model, compare at the falling edge.
    task automatic run(bit m3, bit dbl, logic [63:0] a, logic [63:0] b, logic [63:0] c);
        int ca, cb, cc;
        bit imz, nv, inv, eimz, na, nb, nc;
        logic [1:0] s;
        logic [63:0] r, src;
        string tag;
        @(posedge clk);
        mode3 = m3; is_dbl = dbl; op_a = a; op_b = b; op_c = c;
        ca = tcls(dbl, a); cb = tcls(dbl, b); cc = m3 ? tcls(dbl, c) : 0;
        na = ca >= 3; nb = cb >= 3; nc = cc >= 3;
        imz = m3 && ((ca == 2 && cb == 1) || (ca == 1 && cb == 2));
        nv = 0; s = 0; inv = (ca == 4) || (cb == 4) || (cc == 4); eimz = 0; r = 0;
        if (imz) begin
            nv = 1; inv = 1; eimz = 1; s = nc ? 2'd2 : 2'd3;
            tag = nc ? "R2" : "R3";
        end else if (na || nb || nc) begin
            nv = 1;
            if (!m3) begin
                tag = "R6";
                if (cb == 4) s = 1; else if (ca == 4) s = 0; else if (cb == 3) s = 1; else s = 0;
            end else if (inv) begin
                tag = "R4";
                if (cc == 4) s = 2; else if (cb == 4) s = 1; else s = 0;
            end else begin
                tag = "R5";
                if (cc == 3) s = 2; else if (cb == 3) s = 1; else s = 0;
            end
        end else tag = "R1";
        if (nv) begin
            if (s == 3) r = dbl ? 64'h7FF8000000000000 : 64'h0000_0000_7FC0_0000;
            else begin
                src = (s == 0) ? a : (s == 1) ? b : c;
                r = dbl ? (src | 64'h0008_0000_0000_0000) : {32'h0, src[31:0] | 32'h0040_0000};
            end
        end
        @(negedge clk);
        chk(tag, "nan_valid", 64'(nan_valid), 64'(nv));
        chk(tag, "sel", 64'(sel), 64'(s));
        chk(nv ? (dbl ? "R11" : "R8") : tag, "result", result, r);
        chk("R9", "invalid", 64'(invalid), 64'(inv));
        chk("R9", "invalid_imz", 64'(invalid_imz), 64'(eimz));
        if (!dbl) chk("R10", "result_upper", 64'(result[63:32]), 64'h0);
    endtask

    initial begin
        mode3 = 1; is_dbl = 0; op_a = 0; op_b = 0; op_c = 0;
        void'($urandom(32'd7321));
        @(negedge clk);
        chk("R1", "reset_state_valid", 64'(nan_valid), 64'h0);
        chk("R1", "reset_state_result", result, 64'h0);
        // Exhaustive class sweep, both modes and precisions.
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        for (int k = 0; k < 5; k++)
                            run(m[0], d[0], gen(i, d[0]), gen(j, d[0]), gen(k, d[0]));
        // Random raw patterns.
        for (int n = 0; n < 2000; n++)
            run(1'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
        // R7: C changes have no effect in two-operand mode.
        for (int n = 0; n < 20; n++) begin
            logic [63:0] a, b, r0;
            logic [1:0] s0;
            logic v0, i0;
            a = gen(n % 5, n[0]); b = gen((n / 5) % 5, n[0]);
            run(0, n[0], a, b, gen(4, n[0]));
            r0 = result; s0 = sel; v0 = nan_valid; i0 = invalid;
            run(0, n[0], a, b, gen(2, n[0]));
            chk("R7", "result_c_ignored", result, r0);
            chk("R7", "flags_c_ignored", {59'h0, s0, v0, i0, 1'b0}, {59'h0, sel, nan_valid, invalid, invalid_imz});
        end
        // R2 directed: inf * 0 + sNaN in double, sign kept.
        run(1, 1, 64'hFFF0000000000000, 64'h0, 64'hFFF0000000000123);
        chk("R2", "imz_snan_c", result, 64'hFFF8000000000123);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule